// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits behind the receive side of an Ethernet MAC and stores each incoming frame in a circular buffer held in an internal 32-bit wide memory. Bytes arrive one per clock on a simple valid/last stream. The frame's error and address-class flags come with its final byte. The block packs the bytes into little-endian words. When the frame ends it writes a one-word header in front of the data. The low half of that header is a per-frame status and the high half is the received byte count, FCS included. The next frame then starts at the following 4-byte boundary.

Software consumes frames by reading the memory through a registered read port. It hands space back by writing a read-pointer register, biased 16 bytes below the offset it has consumed up to. The block compares that pointer with its own write pointer to report whether unread frames remain. If a frame would run into space the host still owns, the frame is dropped, a ring-overflow flag is raised and a missed-frame counter advances. A sticky status register also records good frames and overflows signalled by the MAC's receive FIFO. Software clears that register by writing ones.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the write pointer is 0, the read-pointer register reads 0xFFF0, the buffer reports empty, the status register is 0 and the missed-frame counter is 0.
- R2: Every accepted frame gets a header word at its start offset. Bits 31:16 hold the byte count. Bit 0 is 1 when the frame has no error flag. Bits 5:1 hold the error flags in the order alignment, CRC, too long, runt, bad symbol. Bits 15:13 hold the class flags: bit 13 broadcast, bit 14 physical match, bit 15 multicast. All other bits are 0.
- R3: Frame bytes are stored from start+4 onward, with the first byte of each word in bits 7:0.
- R4: After a frame is accepted, the write pointer becomes (start + count + 4) rounded up to a multiple of 4, modulo the ring size. It is updated at the clock edge that takes the last byte.
- R5: The empty output is 1 exactly when (read-pointer register + 16) modulo the ring size equals the write pointer.
- R6: Status bit 0 (0x01) is set when a frame with no error flag is accepted. A frame with an error flag is still stored but does not set bit 0.
- R7: A frame is accepted only if the ring's occupied bytes plus the frame's header and rounded-up data stay below the ring size. Otherwise the frame is dropped: the write pointer is unchanged, status bit 4 (0x10) is set and the missed-frame counter increments by one.
- R8: A pulse on the FIFO-overflow input sets status bit 6 (0x40).
- R9: Writing the status register clears the bits written as 1 and leaves bits written as 0 unchanged. A set in the same cycle wins over the clear.
- R10: The ring holds 8192 << SIZE_IDX bytes. Data running past the end wraps to offset 0. Any byte that lands in the first 16 bytes after the wrap is also copied to the 16-byte slack area that follows the ring end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_err | input | 5 | Error flags, sampled with the last byte |
| rx_kind | input | 3 | Address-class flags {multicast, physical, broadcast}, sampled with the last byte |
| rx_fifo_ovf | input | 1 | MAC receive FIFO overflow pulse |
| host_rdptr_we | input | 1 | Write strobe for the read-pointer register |
| host_rdptr_wdata | input | 16 | Read-pointer value (consumed offset minus 16) |
| host_sts_we | input | 1 | Write strobe for the status register (write-one-to-clear) |
| host_sts_wdata | input | 16 | Status clear mask |
| mem_raddr | input | MEM_AW | Word address of the host memory read port |
| mem_rdata | output | 32 | Read data, one cycle after the address |
| wr_ptr | output | 16 | Hardware write offset in bytes |
| rd_ptr | output | 16 | Read-pointer register value |
| buf_empty | output | 1 | No unread frame in the ring |
| rx_sts | output | 16 | Sticky status: 0x01 good frame, 0x10 ring overflow, 0x40 FIFO overflow |
| missed_cnt | output | MISS_W | Count of frames dropped for lack of space |

## Verification
The status register can be set by hardware and cleared by the host in the same cycle. The bench provokes this by raising the host clear of the good-frame bit on the exact cycle that the last byte of an error-free frame is taken. It then expects the bit to read 1, and expects a second clear on its own to return the bit to 0. The FIFO-overflow flag is also checked against a clear mask of zeros, which must leave the flag unchanged.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int STS_W            = 16;
  localparam int STS_OK_BIT       = 0;
  localparam int STS_RING_OVF_BIT = 4;
  localparam int STS_FIFO_OVF_BIT = 6;
  localparam logic [STS_W-1:0] STS_IMPL_MASK = 16'h0051;

  localparam int ERR_W       = 5;
  localparam int KIND_W      = 3;
  localparam int SLACK_BYTES = 16;
  localparam int PTR_BIAS    = 16;

  typedef enum logic {
    PK_TAKE = 1'b0,
    PK_SKIP = 1'b1
  } pack_state_e;

  // status half of the per-frame header: class flags on top, errors low, good bit at 0
  function automatic logic [15:0] frame_status(input logic [ERR_W-1:0]  err,
                                               input logic [KIND_W-1:0] kind);
    frame_status = {kind, 7'd0, err, ~(|err)};
  endfunction

endpackage

// File: rtl/rxr_packer.sv
module rxr_packer
  import rxr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  input  logic             abort,
  output logic             word_req,
  output logic [31:0]      word_data,
  output logic [CNT_W-1:0] word_off,
  output logic             end_req,
  output logic [CNT_W-1:0] byte_total
);

  pack_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      acc_q, acc_d;
  logic [1:0]       lane;
  logic             take;
  logic             pk_en;

  always_comb begin
    lane      = cnt_q[1:0];
    take      = in_vld && (state_q == PK_TAKE);
    word_data = acc_q;
    word_data[lane*8 +: 8] = in_byte;
    word_req   = take && (in_last || (lane == 2'd3));
    word_off   = {cnt_q[CNT_W-1:2], 2'b00};
    end_req    = take && in_last;
    byte_total = cnt_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    if (take) begin
      if (word_req && abort) begin
        cnt_d   = '0;
        acc_d   = '0;
        state_d = in_last ? PK_TAKE : PK_SKIP;
      end else if (in_last) begin
        cnt_d = '0;
        acc_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        acc_d = (lane == 2'd3) ? 32'd0 : word_data;
      end
    end else if (in_vld && in_last) begin
      state_d = PK_TAKE;
    end
  end

  assign pk_en = in_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PK_TAKE;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else if (pk_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
    end
  end

endmodule

// File: rtl/rxr_space.sv
module rxr_space
  import rxr_pkg::*;
#(
  parameter int PTR_W = 13,
  parameter int CNT_W = 16
) (
  input  logic [PTR_W-1:0] wptr,
  input  logic [15:0]      host_rd,
  input  logic [CNT_W-1:0] word_off,
  output logic             empty,
  output logic             fits,
  output logic [PTR_W-3:0] ring_word,
  output logic             mirror_en,
  output logic [1:0]       slack_word
);

  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] RING_BYTES = SUM_W'(1) << PTR_W;

  logic [15:0]      rd_biased;
  logic [PTR_W-1:0] rd_off;
  logic [PTR_W-1:0] used;
  logic [SUM_W-1:0] need;
  logic [SUM_W-1:0] pos;
  logic [PTR_W-1:0] wrapped;

  always_comb begin
    rd_biased  = host_rd + 16'(PTR_BIAS);
    rd_off     = rd_biased[PTR_W-1:0];
    used       = wptr - rd_off;
    empty      = (rd_off == wptr);
    // header word plus data through this word must leave at least one byte free
    need       = SUM_W'(used) + SUM_W'(word_off) + SUM_W'(8);
    fits       = (need < RING_BYTES);
    pos        = SUM_W'(wptr) + SUM_W'(word_off) + SUM_W'(4);
    wrapped    = pos[PTR_W-1:0];
    ring_word  = wrapped[PTR_W-1:2];
    mirror_en  = (pos >= RING_BYTES) && (wrapped < PTR_W'(SLACK_BYTES));
    slack_word = wrapped[3:2];
  end

endmodule

// File: rtl/rxr_ram.sv
module rxr_ram #(
  parameter int WORDS = 2052,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we_data,
  input  logic [AW-1:0] addr_data,
  input  logic [31:0]   wdata_data,
  input  logic          we_mirror,
  input  logic [AW-1:0] addr_mirror,
  input  logic [31:0]   wdata_mirror,
  input  logic          we_hdr,
  input  logic [AW-1:0] addr_hdr,
  input  logic [31:0]   wdata_hdr,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);

  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we_data)   mem_q[addr_data]   <= wdata_data;
    if (we_mirror) mem_q[addr_mirror] <= wdata_mirror;
    if (we_hdr)    mem_q[addr_hdr]    <= wdata_hdr;
    rdata <= mem_q[raddr];
  end

endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
#(
  parameter int MISS_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ok,
  input  logic              set_ring_ovf,
  input  logic              set_fifo_ovf,
  input  logic              clr_we,
  input  logic [STS_W-1:0]  clr_mask,
  input  logic              miss_inc,
  output logic [STS_W-1:0]  sts,
  output logic [MISS_W-1:0] missed
);

  logic [STS_W-1:0]  sts_q, sts_d, set_vec, clr_vec;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              sts_en, miss_en;

  always_comb begin
    set_vec = '0;
    set_vec[STS_OK_BIT]       = set_ok;
    set_vec[STS_RING_OVF_BIT] = set_ring_ovf;
    set_vec[STS_FIFO_OVF_BIT] = set_fifo_ovf;
    clr_vec = clr_we ? clr_mask : '0;
    sts_d   = ((sts_q & ~clr_vec) | set_vec) & STS_IMPL_MASK;
    sts_en  = clr_we || (|set_vec);
    miss_d  = miss_q + 1'b1;
    miss_en = miss_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
    end else if (miss_en) begin
      miss_q <= miss_d;
    end
  end

  assign sts    = sts_q;
  assign missed = miss_q;

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int SIZE_IDX = 0,
  parameter int MISS_W   = 24,
  localparam int RING_BYTES = 8192 << SIZE_IDX,
  localparam int PTR_W      = $clog2(RING_BYTES),
  localparam int RING_WORDS = RING_BYTES / 4,
  localparam int MEM_WORDS  = RING_WORDS + SLACK_BYTES / 4,
  localparam int MEM_AW     = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [4:0]        rx_err,
  input  logic [2:0]        rx_kind,
  input  logic              rx_fifo_ovf,
  input  logic              host_rdptr_we,
  input  logic [15:0]       host_rdptr_wdata,
  input  logic              host_sts_we,
  input  logic [15:0]       host_sts_wdata,
  input  logic [MEM_AW-1:0] mem_raddr,
  output logic [31:0]       mem_rdata,
  output logic [15:0]       wr_ptr,
  output logic [15:0]       rd_ptr,
  output logic              buf_empty,
  output logic [15:0]       rx_sts,
  output logic [MISS_W-1:0] missed_cnt
);

  localparam int CNT_W = 16;
  localparam int SUM_W = CNT_W + 2;

  logic [PTR_W-1:0]  wptr_q, wptr_d;
  logic              wptr_en;
  logic [15:0]       rd_q;
  logic              rd_en;

  logic              word_req, end_req;
  logic [31:0]       word_data;
  logic [CNT_W-1:0]  word_off, byte_total;

  logic              fits, mirror_en, empty;
  logic [PTR_W-3:0]  ring_word;
  logic [1:0]        slack_word;

  logic              wr_word, abort, commit;
  logic [SUM_W-1:0]  next_sum;
  logic [31:0]       hdr_word;
  logic [MEM_AW-1:0] addr_data, addr_mirror, addr_hdr;

  rxr_packer #(.CNT_W(CNT_W)) u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (rx_valid),
    .in_byte    (rx_data),
    .in_last    (rx_last),
    .abort      (abort),
    .word_req   (word_req),
    .word_data  (word_data),
    .word_off   (word_off),
    .end_req    (end_req),
    .byte_total (byte_total)
  );

  rxr_space #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_space (
    .wptr       (wptr_q),
    .host_rd    (rd_q),
    .word_off   (word_off),
    .empty      (empty),
    .fits       (fits),
    .ring_word  (ring_word),
    .mirror_en  (mirror_en),
    .slack_word (slack_word)
  );

  always_comb begin
    wr_word     = word_req && fits;
    abort       = word_req && !fits;
    commit      = end_req && fits;
    hdr_word    = {byte_total, frame_status(rx_err, rx_kind)};
    addr_data   = MEM_AW'(ring_word);
    addr_mirror = MEM_AW'(RING_WORDS) + MEM_AW'(slack_word);
    addr_hdr    = MEM_AW'(wptr_q[PTR_W-1:2]);
    next_sum    = SUM_W'(wptr_q) + SUM_W'(byte_total) + SUM_W'(7);
    wptr_d      = {next_sum[PTR_W-1:2], 2'b00};
    wptr_en     = commit;
    rd_en       = host_rdptr_we;
  end

  rxr_ram #(.WORDS(MEM_WORDS), .AW(MEM_AW)) u_ram (
    .clk          (clk),
    .we_data      (wr_word),
    .addr_data    (addr_data),
    .wdata_data   (word_data),
    .we_mirror    (wr_word && mirror_en),
    .addr_mirror  (addr_mirror),
    .wdata_mirror (word_data),
    .we_hdr       (commit),
    .addr_hdr     (addr_hdr),
    .wdata_hdr    (hdr_word),
    .raddr        (mem_raddr),
    .rdata        (mem_rdata)
  );

  rxr_status #(.MISS_W(MISS_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_ok       (commit && !(|rx_err)),
    .set_ring_ovf (abort),
    .set_fifo_ovf (rx_fifo_ovf),
    .clr_we       (host_sts_we),
    .clr_mask     (host_sts_wdata),
    .miss_inc     (abort),
    .sts          (rx_sts),
    .missed       (missed_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (wptr_en) begin
      wptr_q <= wptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 16'hFFF0;
    end else if (rd_en) begin
      rd_q <= host_rdptr_wdata;
    end
  end

  assign wr_ptr    = 16'(wptr_q);
  assign rd_ptr    = rd_q;
  assign buf_empty = empty;

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int MISS_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              rx_fifo_ovf,
  input logic [15:0]       wr_ptr,
  input logic [15:0]       rx_sts,
  input logic [MISS_W-1:0] missed_cnt
);

  assert_wptr_moves_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr != $past(wr_ptr)) |-> $past(rx_valid && rx_last));

  assert_missed_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + 1'b1));

  assert_drop_keeps_wptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt != $past(missed_cnt)) |-> $stable(wr_ptr));

  assert_drop_flags_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt != $past(missed_cnt)) |-> rx_sts[4]);

  assert_fifo_ovf_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_fifo_ovf) |-> rx_sts[6]);

endmodule

bind rx_ring_writer rxr_checker #(.MISS_W(MISS_W)) u_rxr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_last     (rx_last),
  .rx_fifo_ovf (rx_fifo_ovf),
  .wr_ptr      (wr_ptr),
  .rx_sts      (rx_sts),
  .missed_cnt  (missed_cnt)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;

  localparam int RING = 8192;

  logic        clk;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_last;
  logic [4:0]  rx_err;
  logic [2:0]  rx_kind;
  logic        rx_fifo_ovf;
  logic        host_rdptr_we;
  logic [15:0] host_rdptr_wdata;
  logic        host_sts_we;
  logic [15:0] host_sts_wdata;
  logic [11:0] mem_raddr;
  logic [31:0] mem_rdata;
  logic [15:0] wr_ptr;
  logic [15:0] rd_ptr;
  logic        buf_empty;
  logic [15:0] rx_sts;
  logic [23:0] missed_cnt;

  int checks;
  int failures;

  rx_ring_writer i_rx_ring_writer (
    .clk              (clk),
    .rst_n            (rst_n),
    .rx_valid         (rx_valid),
    .rx_data          (rx_data),
    .rx_last          (rx_last),
    .rx_err           (rx_err),
    .rx_kind          (rx_kind),
    .rx_fifo_ovf      (rx_fifo_ovf),
    .host_rdptr_we    (host_rdptr_we),
    .host_rdptr_wdata (host_rdptr_wdata),
    .host_sts_we      (host_sts_we),
    .host_sts_wdata   (host_sts_wdata),
    .mem_raddr        (mem_raddr),
    .mem_rdata        (mem_rdata),
    .wr_ptr           (wr_ptr),
    .rd_ptr           (rd_ptr),
    .buf_empty        (buf_empty),
    .rx_sts           (rx_sts),
    .missed_cnt       (missed_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {len[31:16], err[15:11], kind[10:8], seed[7:0]}
  localparam logic [31:0] VEC [8] = '{
    {16'd64,   5'b00000, 3'b010, 8'h10},
    {16'd65,   5'b00000, 3'b001, 8'h20},
    {16'd66,   5'b00000, 3'b100, 8'h30},
    {16'd67,   5'b00000, 3'b010, 8'h40},
    {16'd1518, 5'b00000, 3'b010, 8'h50},
    {16'd60,   5'b00010, 3'b010, 8'h60},
    {16'd77,   5'b01000, 3'b001, 8'h70},
    {16'd200,  5'b00000, 3'b100, 8'h80}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input int seed, input int first);
    exp_data = {8'(seed + first + 3), 8'(seed + first + 2), 8'(seed + first + 1), 8'(seed + first)};
  endfunction

  function automatic logic [31:0] exp_hdr(input int len, input logic [4:0] err, input logic [2:0] kind);
    exp_hdr = {16'(len), kind, 7'd0, err, ~(|err)};
  endfunction

  task automatic send_frame(input int len, input int seed, input logic [4:0] err,
                            input logic [2:0] kind, input logic clr_on_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid       = 1'b1;
      rx_data        = 8'(seed + i);
      rx_last        = (i == len - 1);
      rx_err         = err;
      rx_kind        = kind;
      host_sts_we    = clr_on_last && (i == len - 1);
      host_sts_wdata = 16'h0001;
    end
    @(negedge clk);
    rx_valid    = 1'b0;
    rx_last     = 1'b0;
    host_sts_we = 1'b0;
  endtask

  task automatic read_word(input int idx, output logic [31:0] w);
    @(negedge clk);
    mem_raddr = 12'(idx);
    @(negedge clk);
    w = mem_rdata;
  endtask

  task automatic write_rd(input int v);
    @(negedge clk);
    host_rdptr_we    = 1'b1;
    host_rdptr_wdata = 16'(v);
    @(negedge clk);
    host_rdptr_we    = 1'b0;
  endtask

  task automatic clear_sts(input logic [15:0] m);
    @(negedge clk);
    host_sts_we    = 1'b1;
    host_sts_wdata = m;
    @(negedge clk);
    host_sts_we    = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk("R1 wr_ptr after reset", 32'(wr_ptr), 32'd0);
    chk("R1 rd_ptr after reset", 32'(rd_ptr), 32'h0000FFF0);
    chk("R1 empty after reset", 32'(buf_empty), 32'd1);
    chk("R1 status after reset", 32'(rx_sts), 32'd0);
    chk("R1 missed after reset", 32'(missed_cnt), 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] w;
    int st;
    int nxt;
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_err = '0; rx_kind = '0;
    rx_fifo_ovf = 1'b0;
    host_rdptr_we = 1'b0; host_rdptr_wdata = '0;
    host_sts_we = 1'b0; host_sts_wdata = '0;
    mem_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // table of frames, one pass
    st = 0;
    for (int v = 0; v < 8; v++) begin
      int len;
      logic [4:0] err;
      logic [2:0] kind;
      int seed;
      len  = int'(VEC[v][31:16]);
      err  = VEC[v][15:11];
      kind = VEC[v][10:8];
      seed = int'(VEC[v][7:0]);
      clear_sts(16'h0001);
      send_frame(len, seed, err, kind, 1'b0);
      nxt = ((st + len + 7) & ~3) % RING;
      chk("R4 next frame start", 32'(wr_ptr), 32'(nxt));
      chk("R6 good-frame flag", 32'(rx_sts[0]), 32'(err == 5'd0));
      chk("R5 not empty with unread frames", 32'(buf_empty), 32'd0);
      read_word(st / 4, w);
      chk("R2 header word", w, exp_hdr(len, err, kind));
      read_word((st + 4) / 4, w);
      chk("R3 first data word", w, exp_data(seed, 0));
      st = nxt;
    end

    // R5: host pointer bias
    write_rd(st - 16);
    chk("R5 rd_ptr readback", 32'(rd_ptr), 32'(16'(st - 16)));
    chk("R5 empty when all consumed", 32'(buf_empty), 32'd1);
    write_rd(st - 20);
    chk("R5 not empty one word short", 32'(buf_empty), 32'd0);

    // R1: reset mid-run
    apply_reset();
    check_reset_state();

    // R7: fill the ring, then overrun it
    for (int k = 0; k < 8; k++) begin
      send_frame(1000, k * 16, 5'd0, 3'b010, 1'b0);
    end
    chk("R7 eight frames accepted", 32'(wr_ptr), 32'd8032);
    chk("R7 no miss while space remains", 32'(missed_cnt), 32'd0);
    send_frame(1000, 8'h90, 5'd0, 3'b010, 1'b0);
    chk("R7 dropped frame keeps wr_ptr", 32'(wr_ptr), 32'd8032);
    chk("R7 missed counter", 32'(missed_cnt), 32'd1);
    chk("R7 ring overflow flag", 32'(rx_sts[4]), 32'd1);

    // R10: free everything, then a frame crossing the ring end
    write_rd(8032 - 16);
    chk("R5 empty after free", 32'(buf_empty), 32'd1);
    send_frame(200, 8'hA0, 5'd0, 3'b010, 1'b0);
    chk("R10 wrapped next start", 32'(wr_ptr), 32'd44);
    chk("R7 accepted after free", 32'(missed_cnt), 32'd1);
    read_word(8032 / 4, w);
    chk("R10 header before end", w, exp_hdr(200, 5'd0, 3'b010));
    read_word(0, w);
    chk("R10 wrapped data at offset 0", w, exp_data(8'hA0, 156));
    read_word(RING / 4, w);
    chk("R10 slack mirror word 0", w, exp_data(8'hA0, 156));
    read_word(RING / 4 + 3, w);
    chk("R10 slack mirror word 3", w, exp_data(8'hA0, 168));
    read_word(10, w);
    chk("R10 last wrapped data word", w, exp_data(8'hA0, 196));

    // R8 / R9: sticky bits and write-one-to-clear
    clear_sts(16'hFFFF);
    chk("R9 clear all", 32'(rx_sts), 32'd0);
    @(negedge clk);
    rx_fifo_ovf = 1'b1;
    @(negedge clk);
    rx_fifo_ovf = 1'b0;
    chk("R8 fifo overflow flag", 32'(rx_sts), 32'h40);
    clear_sts(16'h0000);
    chk("R9 zero mask leaves bits", 32'(rx_sts), 32'h40);
    clear_sts(16'h0040);
    chk("R9 clear fifo flag", 32'(rx_sts), 32'd0);

    // R9: set and clear in the same cycle
    send_frame(64, 8'hC0, 5'd0, 3'b001, 1'b1);
    chk("R9 set wins over clear", 32'(rx_sts[0]), 32'd1);
    chk("R4 frame after wrap", 32'(wr_ptr), 32'd112);
    clear_sts(16'h0001);
    chk("R9 later clear takes effect", 32'(rx_sts[0]), 32'd0);

    summary();
    $finish;
  end

endmodule